// File: doc/BRIEF.md
# Packet buffer pointer window

This block gives a host processor byte access to a small on-chip packet memory. The memory is split into equal slots of 2048 bytes, one per packet. The host does not address the memory directly. It loads a 16-bit pointer register, one byte at a time, over a byte-wide register bus. It then moves packet bytes through a four-byte data window.

Two control bits in the pointer set how the window behaves. The top bit picks the slot. When it is set, the slot is the packet number at the head of the receive completion queue. When it is clear, the slot is the transmit packet number that the host selected. A second bit picks the addressing mode:

- **Streaming mode:** every byte access moves the pointer on by one.
- **Windowed mode:** the pointer stays fixed, and the four window addresses reach four consecutive bytes.

The memory sits inside the block. The two packet numbers come from surrounding logic.

Top module: `pkt_window`

## Requirements
- R1: After reset the pointer holds 0x0000, and read data is 0x00 until the first read completes.
- R2: A write to bus offset 6 loads pointer bits 7:0. A write to offset 7 loads pointer bits 15:8. The other pointer byte stays as it was.
- R3: A read of offset 6 returns pointer bits 7:0. A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so that bit position 3 of the result always reads 0.
- R4: A data access (offset 8, 9, 10 or 11) uses the receive-queue head number as its slot when pointer bit 15 is 1. It uses the transmit packet number when pointer bit 15 is 0. Each slot is 2048 bytes, and the memory byte address is {slot, byte offset}.
- R5: When pointer bit 14 is 1, a data access uses byte offset = pointer bits 10:0. After the access, bits 10:0 advance by one modulo 2048 and bits 15:11 do not change. The low two bus address bits are ignored in this mode.
- R6: When pointer bit 14 is 0, a data access uses byte offset = (pointer bits 10:0 + bus address bits 1:0) modulo 2048, and the pointer does not change.
- R7: Read data appears on the read-data output in the cycle after the read strobe is sampled. A streaming read returns the byte at the address the pointer held before it advanced.
- R8: A write to any offset other than 6 to 11 changes neither the pointer nor the memory. A read of any such offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset within the block |
| bus_we | input | 1 | Byte write strobe (has priority over bus_re) |
| bus_re | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_re |
| tx_pkt_num | input | SLOT_W | Transmit packet number chosen by the host |
| rx_head_num | input | SLOT_W | Packet number at the head of the receive queue |

## Verification
A pointer that fails to advance, or advances at the wrong time, shows up at once. The next streaming access reads or writes the wrong byte. A read of offset 6 also returns a low byte that differs from the access count. A wrong slot choice or a wrong windowed sum returns pattern bytes from another slot or offset on the very next read, one cycle later. Wrap faults at offset 2047 also corrupt the high pointer byte, which shows up on a read of offset 7.

// File: rtl/pkt_window.sv
module pkt_window #(
  parameter int SLOTS      = 2,
  parameter int OFF_W      = 11,
  parameter int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [SLOT_W-1:0] tx_pkt_num,
  input  logic [SLOT_W-1:0] rx_head_num
);
  localparam int MA_W  = SLOT_W + OFF_W;
  localparam int DEPTH = SLOTS << OFF_W;

  typedef enum logic [1:0] {RS_NONE, RS_PLO, RS_PHI, RS_MEM} rsel_t;

  logic [15:0]       ptr;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        mem_q;
  rsel_t             rsel;

  wire win_hit   = (bus_addr[3:2] == 2'b10);
  wire acc       = (bus_we | bus_re) & win_hit;
  wire wr_acc    = bus_we & win_hit;
  wire rd_acc    = bus_re & ~bus_we & win_hit;
  wire auto_inc  = ptr[14];
  wire [SLOT_W-1:0] slot = ptr[15] ? rx_head_num : tx_pkt_num;
  wire [OFF_W-1:0]  off  = auto_inc ? ptr[OFF_W-1:0]
                                    : ptr[OFF_W-1:0] + OFF_W'(bus_addr[1:0]);
  wire [MA_W-1:0]   maddr = {slot, off};

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (bus_we && bus_addr == 4'd6)
      ptr[7:0] <= bus_wdata;
    else if (bus_we && bus_addr == 4'd7)
      ptr[15:8] <= bus_wdata;
    else if (acc && auto_inc)
      ptr[OFF_W-1:0] <= ptr[OFF_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_acc)
      mem[maddr] <= bus_wdata;
    if (rd_acc)
      mem_q <= mem[maddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rsel <= RS_NONE;
    else if (bus_re && !bus_we) begin
      if (win_hit)               rsel <= RS_MEM;
      else if (bus_addr == 4'd6) rsel <= RS_PLO;
      else if (bus_addr == 4'd7) rsel <= RS_PHI;
      else                       rsel <= RS_NONE;
    end
  end

  logic [7:0] plo_q, phi_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plo_q <= '0;
      phi_q <= '0;
    end else if (bus_re && !bus_we) begin
      plo_q <= ptr[7:0];
      phi_q <= ptr[15:8] & 8'hF7;
    end
  end

  always_comb begin
    case (rsel)
      RS_PLO:  bus_rdata = plo_q;
      RS_PHI:  bus_rdata = phi_q;
      RS_MEM:  bus_rdata = mem_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_ptr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd6) |=> (ptr[7:0] == $past(bus_wdata)) && $stable(ptr[15:8]));

  assert_ptr_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd7) |=> (ptr[15:8] == $past(bus_wdata)) && $stable(ptr[7:0]));

  assert_hi_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && bus_addr == 4'd7) |=> (bus_rdata[3] == 1'b0));

  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ptr[14]) |=> (ptr[OFF_W-1:0] == $past(ptr[OFF_W-1:0]) + 1'b1) && $stable(ptr[15:OFF_W]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ptr[14]) |=> $stable(ptr));

  assert_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && !win_hit && bus_addr != 4'd6 && bus_addr != 4'd7) |=> (bus_rdata == 8'h00));

  assert_other_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !win_hit && bus_addr != 4'd6 && bus_addr != 4'd7) |=> $stable(ptr));
endmodule

// File: tb/pkt_window_tb_top.sv
module pkt_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [0:0] tx_pkt_num = '0;
  logic [0:0] rx_head_num = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pkt_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pkt_num(tx_pkt_num), .rx_head_num(rx_head_num)
  );

  function automatic logic [7:0] pat(input int s, input int o);
    return 8'((s * 37 + o * 5 + 3) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(4'd6, p[7:0]);
    wr(4'd7, p[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    rd(4'd6, v); chk("R1 ptr low", v, 8'h00);
    rd(4'd7, v); chk("R1 ptr high", v, 8'h00);
  endtask

  task automatic t_ptr_regs();
    logic [7:0] v;
    wr(4'd6, 8'hA5);
    wr(4'd7, 8'hFF);
    rd(4'd6, v); chk("R2 low byte", v, 8'hA5);
    rd(4'd7, v); chk("R3 high byte masked", v, 8'hF7);
    wr(4'd6, 8'h3C);
    rd(4'd7, v); chk("R2 high kept", v, 8'hF7);
    rd(4'd6, v); chk("R2 low reload", v, 8'h3C);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    set_ptr(16'h0102);
    wr(4'd3, 8'h55);
    wr(4'd13, 8'hAA);
    wr(4'd0, 8'hFF);
    rd(4'd6, v); chk("R8 ptr low untouched", v, 8'h02);
    rd(4'd7, v); chk("R8 ptr high untouched", v, 8'h01);
    rd(4'd3, v); chk("R8 other offset reads zero", v, 8'h00);
    rd(4'd15, v); chk("R8 offset 15 reads zero", v, 8'h00);
  endtask

  task automatic t_fill();
    logic [7:0] v;
    tx_pkt_num = 1'b1;
    set_ptr(16'h4000);
    for (int i = 0; i < 16; i++) wr(4'(8 + (i % 4)), pat(1, i));
    rd(4'd6, v); chk("R5 ptr advanced by writes", v, 8'd16);
    rx_head_num = 1'b0;
    set_ptr(16'hC000);
    for (int i = 0; i < 16; i++) wr(4'd8, pat(0, i));
    rd(4'd6, v); chk("R5 rx fill advanced", v, 8'd16);
    rd(4'd7, v); chk("R5 high unchanged", v, 8'hC0);
  endtask

  task automatic t_fixed();
    logic [7:0] v;
    tx_pkt_num = 1'b1;
    set_ptr(16'h0004);
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), v); chk("R6 R7 windowed read", v, pat(1, 4 + k));
    end
    rd(4'd6, v); chk("R6 ptr held", v, 8'h04);
    wr(4'd10, 8'h9E);
    rd(4'd10, v); chk("R6 windowed write", v, 8'h9E);
    rd(4'd8, v); chk("R6 neighbour intact", v, pat(1, 4));
    wr(4'd10, pat(1, 6));
  endtask

  task automatic t_rxsel();
    logic [7:0] v;
    tx_pkt_num = 1'b1;
    rx_head_num = 1'b0;
    set_ptr(16'h8008);
    rd(4'd9, v); chk("R4 rx head slot 0", v, pat(0, 9));
    rx_head_num = 1'b1;
    rd(4'd9, v); chk("R4 rx head slot 1", v, pat(1, 9));
    tx_pkt_num = 1'b0;
    set_ptr(16'h0008);
    rd(4'd11, v); chk("R4 tx slot 0", v, pat(0, 11));
  endtask

  task automatic t_autoread();
    logic [7:0] v;
    tx_pkt_num = 1'b1;
    set_ptr(16'h4002);
    for (int k = 0; k < 4; k++) begin
      rd(4'd11, v); chk("R5 R7 streaming read", v, pat(1, 2 + k));
    end
    rd(4'd6, v); chk("R5 ptr after reads", v, 8'h06);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    tx_pkt_num = 1'b1;
    set_ptr(16'h7FFE);
    wr(4'd8, 8'hA1);
    wr(4'd8, 8'hB2);
    wr(4'd8, 8'hC3);
    rd(4'd6, v); chk("R5 wrap low", v, 8'h01);
    rd(4'd7, v); chk("R5 wrap high kept", v, 8'h70);
    set_ptr(16'h07FE);
    rd(4'd8, v);  chk("R6 offset 2046", v, 8'hA1);
    rd(4'd9, v);  chk("R6 offset 2047", v, 8'hB2);
    rd(4'd10, v); chk("R6 sum wraps to 0", v, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_regs();
    t_ignored();
    t_fill();
    t_fixed();
    t_rxsel();
    t_autoread();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule